// File: doc/BRIEF.md
# Resource Tag Stream Parser with Identifier Capture

This block consumes a byte stream of resource tag records, as read out of a small nonvolatile memory at power-up, and pulls one 8-byte identifier out of it. Each record starts with a header byte. A short record carries its name and a 3-bit data length in that header byte. A long record carries a 7-bit name and is followed by a 16-bit length. The parser skips every record by its length, except for one chosen long record. Inside that record it walks a list of keyword subfields. Each subfield has a name byte and a 16-bit length. When it meets the identifier keyword, it keeps the eight bytes that follow that subfield's header, along with the stream position of the first of those bytes.

Bytes arrive one per cycle while `in_valid` is high. `in_last` marks the final byte the memory reader will supply. The parser numbers the accepted bytes from zero after reset. Parsing stops at the terminating short record, at the end of the stream, or when a record would reach past a configurable byte limit. It then holds its results until the next reset. A consumer waits for `done` and uses the identifier only when `found` is also high.

Top module: `rtag_parser`

## Requirements
- R1: After reset, `done` and `found` are low, and `id_value` and `id_offset` are zero.
- R2: A header byte with bit 7 clear is a short record. Bits 6:3 hold its name and bits 2:0 its data length N. The record occupies 1+N bytes, and the next header follows right after them.
- R3: A short record named 0xF ends the parse. `done` is high in the cycle after that header byte is accepted. Every later byte is ignored and all outputs stay frozen.
- R4: A header byte with bit 7 set is a long record. Bits 6:0 hold its name. Its length L is the next two bytes, low byte first, and the record occupies 3+L bytes. Long records not named 0x0D are skipped whole.
- R5: The L data bytes of a long record named 0x0D are walked as subfields. A subfield's name is bits 5:0 of its first byte, and bits 7:6 are ignored. Its length S follows in two bytes, low byte first, and the subfield occupies 3+S bytes. When the record's L bytes run out, the walk stops even in the middle of a subfield, and the next byte is a header.
- R6: In a subfield named 0x3C, the eight bytes right after its 3-byte header are captured. The first of them lands in bits 63:56 and the last in bits 7:0. `id_offset` gives the zero-based stream index of the first of those bytes.
- R7: `found` is high only together with `done`, after a parse ended by the terminating record, once eight identifier bytes have been captured. Only the first complete capture is kept. While `found` is low, `id_value` and `id_offset` read zero.
- R8: An identifier subfield pattern inside any long record other than 0x0D is never captured.
- R9: If the byte flagged by `in_last` is accepted and does not end the parse, `done` rises with `found` low.
- R10: If a header byte arrives at an index at or beyond `LIMIT`, or a record's last byte would fall at an index at or beyond `LIMIT`, `done` rises with `found` low. For a long record, this takes effect in the cycle after its second length byte.
- R11: An identifier subfield that ends, or is cut off by the end of its record, before eight bytes is not a capture. A later complete one is still taken.
- R12: A cycle with `in_valid` low consumes nothing and does not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stream byte is present this cycle |
| in_byte | input | 8 | Stream byte |
| in_last | input | 1 | This byte is the last one the stream will supply |
| id_value | output | 8*ID_BYTES (64) | Captured identifier, first byte most significant |
| id_offset | output | IDX_W (16) | Stream index of the first identifier byte |
| found | output | 1 | Parse finished with a complete identifier |
| done | output | 1 | Parse finished, by any cause |

## Verification
The hardest situation to reach is a long record whose declared length disagrees with the subfields inside it. There, an identifier body is cut short by the record boundary, and the parser must fall back to reading a header in the middle of what looked like subfield data. The random streams reach it by building well-formed records and then nudging the declared record length up or down by a few bytes. This shifts every later header onto arbitrary bytes and also produces records that overrun the limit. Directed streams cover a short identifier followed by a full one, an identifier with the upper name bits set, identifier patterns under a foreign record, and garbage after the terminator.

// File: rtl/rtag_pkg.sv
package rtag_pkg;

    // Default codes of the records the parser cares about
    localparam logic [3:0] END_NAME_DEF = 4'hF;
    localparam logic [6:0] KEY_TAG_DEF  = 7'h0D;
    localparam logic [5:0] KEY_SUB_DEF  = 6'h3C;

    typedef enum logic [3:0] {
        ST_HDR,
        ST_LLEN0,
        ST_LLEN1,
        ST_SKIP,
        ST_SUBHDR,
        ST_SLEN0,
        ST_SLEN1,
        ST_SUBBODY,
        ST_DONE
    } walk_st_e;

    typedef enum logic [1:0] {
        FIN_NONE,
        FIN_OK,
        FIN_ERR
    } fin_e;

    typedef struct packed {
        logic       is_large;
        logic [6:0] big_name;
        logic [3:0] small_name;
        logic [2:0] small_len;
    } tag_hdr_t;

    function automatic tag_hdr_t decode_hdr(input logic [7:0] b);
        tag_hdr_t h;
        h.is_large   = b[7];
        h.big_name   = b[6:0];
        h.small_name = b[6:3];
        h.small_len  = b[2:0];
        return h;
    endfunction

endpackage

// File: rtl/rtag_index.sv
module rtag_index #(
    parameter int IDX_W = 16,
    parameter int LIMIT = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    output logic [IDX_W-1:0] idx,
    output logic             over
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (take) begin
            idx <= idx + 1'b1;
        end
    end

    assign over = ({1'b0, idx} >= (IDX_W+1)'(LIMIT));
endmodule

// File: rtl/rtag_capture.sv
module rtag_capture #(
    parameter int ID_BYTES = 8,
    parameter int IDX_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  arm,
    input  logic [IDX_W-1:0]      arm_off,
    input  logic                  byte_en,
    input  logic [7:0]            byte_in,
    output logic [8*ID_BYTES-1:0] value,
    output logic [IDX_W-1:0]      offset,
    output logic                  complete
);
    localparam int ID_W  = 8 * ID_BYTES;
    localparam int CNT_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

    logic [CNT_W-1:0] cnt;
    logic             active;

    always_ff @(posedge clk) begin
        if (rst) begin
            value    <= '0;
            offset   <= '0;
            cnt      <= '0;
            active   <= 1'b0;
            complete <= 1'b0;
        end else if (!complete) begin
            if (arm) begin
                active <= 1'b1;
                cnt    <= '0;
                offset <= arm_off;
            end else if (byte_en && active) begin
                value <= {value[ID_W-9:0], byte_in};
                if (cnt == CNT_W'(ID_BYTES - 1)) begin
                    complete <= 1'b1;
                    active   <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtag_walker.sv
module rtag_walker
    import rtag_pkg::*;
#(
    parameter int         IDX_W    = 16,
    parameter int         LIMIT    = 512,
    parameter logic [3:0] END_NAME = END_NAME_DEF,
    parameter logic [6:0] KEY_TAG  = KEY_TAG_DEF,
    parameter logic [5:0] KEY_SUB  = KEY_SUB_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_last,
    input  logic [IDX_W-1:0] idx,
    input  logic             over,
    output logic             take,
    output logic             id_arm,
    output logic [IDX_W-1:0] id_arm_off,
    output logic             id_byte,
    output logic             done,
    output logic             ok
);
    localparam int EXT_W = ((IDX_W > 16) ? IDX_W : 16) + 1;

    walk_st_e    st, st_n;
    logic [15:0] remain, remain_n;
    logic [15:0] region, region_n;
    logic [7:0]  len_lo, len_lo_n;
    logic        key_q, key_n;
    logic        sub_id_q, sub_id_n;
    fin_e        fin;
    tag_hdr_t    hdr;
    logic [15:0] len16;

    function automatic logic reaches_limit(input logic [IDX_W-1:0] at,
                                           input logic [15:0]      n);
        return (EXT_W'(at) + EXT_W'(n)) >= EXT_W'(LIMIT);
    endfunction

    assign take       = in_valid && !done;
    assign hdr        = decode_hdr(in_byte);
    assign len16      = {in_byte, len_lo};
    assign id_arm_off = idx + 1'b1;

    always_comb begin
        st_n     = st;
        remain_n = remain;
        region_n = region;
        len_lo_n = len_lo;
        key_n    = key_q;
        sub_id_n = sub_id_q;
        fin      = FIN_NONE;
        id_arm   = 1'b0;
        id_byte  = 1'b0;
        if (take) begin
            if (over) begin
                fin = FIN_ERR;
            end else begin
                unique case (st)
                    ST_HDR: begin
                        if (hdr.is_large) begin
                            key_n = (hdr.big_name == KEY_TAG);
                            st_n  = ST_LLEN0;
                        end else if (hdr.small_name == END_NAME) begin
                            fin = FIN_OK;
                        end else if (reaches_limit(idx, 16'(hdr.small_len))) begin
                            fin = FIN_ERR;
                        end else if (hdr.small_len != 3'd0) begin
                            remain_n = 16'(hdr.small_len);
                            st_n     = ST_SKIP;
                        end
                    end
                    ST_LLEN0: begin
                        len_lo_n = in_byte;
                        st_n     = ST_LLEN1;
                    end
                    ST_LLEN1: begin
                        if (reaches_limit(idx, len16)) begin
                            fin = FIN_ERR;
                        end else if (len16 == 16'd0) begin
                            st_n = ST_HDR;
                        end else if (key_q) begin
                            region_n = len16;
                            st_n     = ST_SUBHDR;
                        end else begin
                            remain_n = len16;
                            st_n     = ST_SKIP;
                        end
                    end
                    ST_SKIP: begin
                        remain_n = remain - 16'd1;
                        if (remain == 16'd1) st_n = ST_HDR;
                    end
                    ST_SUBHDR: begin
                        region_n = region - 16'd1;
                        sub_id_n = (in_byte[5:0] == KEY_SUB);
                        st_n     = (region == 16'd1) ? ST_HDR : ST_SLEN0;
                    end
                    ST_SLEN0: begin
                        region_n = region - 16'd1;
                        len_lo_n = in_byte;
                        st_n     = (region == 16'd1) ? ST_HDR : ST_SLEN1;
                    end
                    ST_SLEN1: begin
                        region_n = region - 16'd1;
                        id_arm   = sub_id_q;
                        if (region == 16'd1) begin
                            st_n = ST_HDR;
                        end else if (len16 == 16'd0) begin
                            st_n = ST_SUBHDR;
                        end else begin
                            remain_n = len16;
                            st_n     = ST_SUBBODY;
                        end
                    end
                    ST_SUBBODY: begin
                        region_n = region - 16'd1;
                        remain_n = remain - 16'd1;
                        id_byte  = sub_id_q;
                        if (region == 16'd1) begin
                            st_n = ST_HDR;
                        end else if (remain == 16'd1) begin
                            st_n = ST_SUBHDR;
                        end
                    end
                    default: st_n = ST_DONE;
                endcase
            end
            if (fin == FIN_NONE && in_last) fin = FIN_ERR;
            if (fin != FIN_NONE) st_n = ST_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_HDR;
            remain   <= '0;
            region   <= '0;
            len_lo   <= '0;
            key_q    <= 1'b0;
            sub_id_q <= 1'b0;
            done     <= 1'b0;
            ok       <= 1'b0;
        end else begin
            st       <= st_n;
            remain   <= remain_n;
            region   <= region_n;
            len_lo   <= len_lo_n;
            key_q    <= key_n;
            sub_id_q <= sub_id_n;
            if (fin != FIN_NONE) begin
                done <= 1'b1;
                ok   <= (fin == FIN_OK);
            end
        end
    end
endmodule

// File: rtl/rtag_parser.sv
module rtag_parser
    import rtag_pkg::*;
#(
    parameter int IDX_W    = 16,
    parameter int LIMIT    = 512,
    parameter int ID_BYTES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [7:0]            in_byte,
    input  logic                  in_last,
    output logic [8*ID_BYTES-1:0] id_value,
    output logic [IDX_W-1:0]      id_offset,
    output logic                  found,
    output logic                  done
);
    logic                  take;
    logic [IDX_W-1:0]      idx;
    logic                  over;
    logic                  id_arm;
    logic [IDX_W-1:0]      id_arm_off;
    logic                  id_byte;
    logic                  ok;
    logic [8*ID_BYTES-1:0] cap_value;
    logic [IDX_W-1:0]      cap_offset;
    logic                  cap_complete;

    rtag_index #(.IDX_W(IDX_W), .LIMIT(LIMIT)) u_index (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .idx  (idx),
        .over (over)
    );

    rtag_walker #(
        .IDX_W    (IDX_W),
        .LIMIT    (LIMIT),
        .END_NAME (END_NAME_DEF),
        .KEY_TAG  (KEY_TAG_DEF),
        .KEY_SUB  (KEY_SUB_DEF)
    ) u_walker (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_last    (in_last),
        .idx        (idx),
        .over       (over),
        .take       (take),
        .id_arm     (id_arm),
        .id_arm_off (id_arm_off),
        .id_byte    (id_byte),
        .done       (done),
        .ok         (ok)
    );

    rtag_capture #(.ID_BYTES(ID_BYTES), .IDX_W(IDX_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .arm      (id_arm && take),
        .arm_off  (id_arm_off),
        .byte_en  (id_byte && take),
        .byte_in  (in_byte),
        .value    (cap_value),
        .offset   (cap_offset),
        .complete (cap_complete)
    );

    assign found     = done && ok && cap_complete;
    assign id_value  = found ? cap_value  : '0;
    assign id_offset = found ? cap_offset : '0;
endmodule

// File: rtl/rtag_parser_chk.sv
module rtag_parser_chk #(
    parameter int IDX_W    = 16,
    parameter int LIMIT    = 512,
    parameter int ID_BYTES = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  done,
    input logic                  found,
    input logic [8*ID_BYTES-1:0] id_value,
    input logic [IDX_W-1:0]      id_offset
);
    // R3: once finished, the parser stays finished
    p_done_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R3: results are frozen after the finish
    p_results_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(found) && $stable(id_value) && $stable(id_offset)));

    // R7: a found identifier only appears with a finished parse
    p_found_needs_done_r7: assert property (@(posedge clk) disable iff (rst)
        found |-> done);

    // R6: identifier bytes cannot start before a long header and a subfield header
    p_offset_floor_r6: assert property (@(posedge clk) disable iff (rst)
        found |-> (id_offset >= IDX_W'(6)));

    // R10: a captured identifier lies wholly below the limit
    p_offset_in_limit_r10: assert property (@(posedge clk) disable iff (rst)
        found |-> ((int'(id_offset) + ID_BYTES) <= LIMIT));
endmodule

bind rtag_parser rtag_parser_chk #(
    .IDX_W    (IDX_W),
    .LIMIT    (LIMIT),
    .ID_BYTES (ID_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .done      (done),
    .found     (found),
    .id_value  (id_value),
    .id_offset (id_offset)
);

// File: tb/sim_rtag_parser.sv
module sim_rtag_parser;
    localparam int LIM = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_last = 1'b0;
    logic [63:0] id_value;
    logic [15:0] id_offset;
    logic        found;
    logic        done;

    int checks = 0;
    int errors = 0;

    logic [7:0] strm [0:1023];
    int n = 0;

    always #5 clk = ~clk;

    rtag_parser #(.IDX_W(16), .LIMIT(LIM), .ID_BYTES(8)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_last   (in_last),
        .id_value  (id_value),
        .id_offset (id_offset),
        .found     (found),
        .done      (done)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_stream();
        for (int k = 0; k < 1024; k++) strm[k] = 8'h00;
        n = 0;
    endtask

    task automatic push(input logic [7:0] b);
        strm[n] = b;
        n++;
    endtask

    task automatic push_id(input logic [7:0] name, input logic [63:0] v);
        push(name); push(8'h08); push(8'h00);
        for (int k = 7; k >= 0; k--) push(v[8*k +: 8]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // one byte, outputs sampled at the following falling edge
    task automatic send(input logic [7:0] b, input logic last);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_last = last;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_byte = 8'h78;
    endtask

    task automatic feed_all(input bit gaps);
        for (int k = 0; k < n; k++) begin
            if (gaps) begin
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    in_valid = 1'b0; in_last = 1'b0; in_byte = 8'($urandom);
                end
            end
            @(negedge clk);
            in_valid = 1'b1; in_byte = strm[k]; in_last = (k == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        @(negedge clk);
    endtask

    // walks the stream the way the requirements read
    function automatic void ref_parse(output bit ok, output bit fnd,
                                      output logic [63:0] v, output int off);
        int i = 0;
        bit have = 1'b0;
        logic [63:0] hv = '0;
        int ho = 0;
        ok = 1'b0; fnd = 1'b0; v = '0; off = 0;
        while (1'b1) begin
            logic [7:0] b;
            if (i >= n || i >= LIM) return;
            b = strm[i];
            if (!b[7]) begin
                int len;
                if (b[6:3] == 4'hF) begin
                    ok = 1'b1; fnd = have;
                    v = have ? hv : '0; off = have ? ho : 0;
                    return;
                end
                len = int'(b[2:0]);
                if (i + len >= LIM) return;
                i += 1 + len;
            end else begin
                int len;
                if (i + 2 >= n || i + 2 >= LIM) return;
                len = int'(strm[i+1]) + 256 * int'(strm[i+2]);
                if (i + 2 + len >= LIM) return;
                if (b[6:0] == 7'h0D) begin
                    int j = i + 3;
                    int e = i + 3 + len;
                    while (j + 2 < e) begin
                        int sl = int'(strm[j+1]) + 256 * int'(strm[j+2]);
                        if (strm[j][5:0] == 6'h3C && !have && sl >= 8 && j + 11 <= e) begin
                            have = 1'b1;
                            ho = j + 3;
                            for (int q = 0; q < 8; q++) hv = {hv[55:0], strm[j+3+q]};
                        end
                        j += 3 + sl;
                    end
                end
                i += 3 + len;
            end
        end
    endfunction

    task automatic run_model(input string tag, input bit gaps);
        bit ok, fnd;
        logic [63:0] v;
        int off;
        ref_parse(ok, fnd, v, off);
        do_reset();
        feed_all(gaps);
        check(tag, {63'd0, done}, 64'd1);
        check(tag, {63'd0, found}, {63'd0, fnd});
        check(tag, id_value, v);
        check(tag, {48'd0, id_offset}, 64'(off));
    endtask

    task automatic gen_random();
        clear_stream();
        repeat ($urandom_range(0, 6)) begin
            int kind = $urandom_range(0, 9);
            if (kind < 3) begin
                logic [3:0] nm = 4'($urandom_range(0, 14));
                logic [2:0] ln = 3'($urandom);
                push({1'b0, nm, ln});
                for (int k = 0; k < int'(ln); k++) push(8'($urandom));
            end else if (kind < 7) begin
                int hpos = n;
                int body = 0;
                int decl;
                push(8'h8D); push(8'h00); push(8'h00);
                repeat ($urandom_range(1, 3)) begin
                    logic [7:0] nm = ($urandom_range(0, 9) < 4) ?
                        {2'($urandom), 6'h3C} : 8'($urandom);
                    int sl = ($urandom_range(0, 1) == 1) ? 8 : $urandom_range(0, 12);
                    push(nm); push(8'(sl)); push(8'h00);
                    for (int k = 0; k < sl; k++) push(8'($urandom));
                    body += 3 + sl;
                end
                decl = body;
                if ($urandom_range(0, 4) == 0) decl = body + $urandom_range(0, 4) - 2;
                if (decl < 0) decl = 0;
                strm[hpos+1] = 8'(decl);
                strm[hpos+2] = 8'(decl >> 8);
            end else begin
                int ln = $urandom_range(0, 10);
                push({1'b1, 7'($urandom)}); push(8'(ln)); push(8'h00);
                for (int k = 0; k < ln; k++) push(8'($urandom));
            end
        end
        if ($urandom_range(0, 99) < 85) push({5'b01111, 3'($urandom)});
        repeat ($urandom_range(0, 3)) push(8'($urandom));
        if (n == 0) push(8'h78);
        if ($urandom_range(0, 9) == 0) n = $urandom_range(1, n);
    endtask

    initial begin
        #(20_000 * 10);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_stream();

        // R1: reset state
        do_reset();
        @(negedge clk);
        check("R1", {63'd0, done}, 64'd0);
        check("R1", {63'd0, found}, 64'd0);
        check("R1", id_value, 64'd0);
        check("R1", {48'd0, id_offset}, 64'd0);

        // R6 and R3: basic capture, done only after the terminator
        do_reset();
        send(8'h8D, 1'b0); send(8'h0B, 1'b0); send(8'h00, 1'b0);
        send(8'h3C, 1'b0); send(8'h08, 1'b0); send(8'h00, 1'b0);
        for (int k = 1; k <= 8; k++) send(8'(k * 17), 1'b0);
        check("R3", {63'd0, done}, 64'd0);
        send(8'h7A, 1'b0);
        check("R3", {63'd0, done}, 64'd1);
        check("R6", id_value, 64'h1122334455667788);
        check("R6", {48'd0, id_offset}, 64'd6);
        check("R7", {63'd0, found}, 64'd1);
        // R3: garbage after the terminator changes nothing
        send(8'h8D, 1'b0); send(8'h00, 1'b1);
        check("R3", id_value, 64'h1122334455667788);
        check("R3", {63'd0, found}, 64'd1);

        // R12: idle cycles carrying a terminator byte consume nothing
        do_reset();
        @(negedge clk); in_valid = 1'b0; in_byte = 8'h78;
        repeat (4) @(negedge clk);
        check("R12", {63'd0, done}, 64'd0);
        send(8'h10, 1'b0);
        check("R12", {63'd0, done}, 64'd0);
        send(8'h78, 1'b0);
        check("R12", {63'd0, done}, 64'd1);

        // R10: long record reaching past the limit ends after its second length byte
        do_reset();
        send(8'h91, 1'b0); send(8'h00, 1'b0);
        check("R10", {63'd0, done}, 64'd0);
        send(8'h03, 1'b0);
        check("R10", {63'd0, done}, 64'd1);
        check("R10", {63'd0, found}, 64'd0);

        // R2: short records skipped before the keyed record
        clear_stream();
        push(8'h12); push(8'hAA); push(8'h78);
        push(8'h20);
        push(8'h8D); push(8'h0B); push(8'h00);
        push_id(8'h3C, 64'hA1A2A3A4A5A6A7A8);
        push(8'h78);
        run_model("R2", 1'b0);

        // R8: identifier pattern under a foreign long record
        clear_stream();
        push(8'h90); push(8'h0B); push(8'h00);
        push_id(8'h3C, 64'h0102030405060708);
        push(8'h78);
        run_model("R8", 1'b0);

        // R5: upper name bits ignored, other subfield skipped first
        clear_stream();
        push(8'h8D); push(8'h10); push(8'h00);
        push(8'h01); push(8'h02); push(8'h00); push(8'h55); push(8'h66);
        push_id(8'hFC, 64'hCAFEF00DDEADBEEF);
        push(8'h78);
        run_model("R5", 1'b1);

        // R11: short identifier subfield, then a complete one
        clear_stream();
        push(8'h8D); push(8'h12); push(8'h00);
        push(8'h3C); push(8'h04); push(8'h00);
        push(8'h11); push(8'h22); push(8'h33); push(8'h44);
        push_id(8'h3C, 64'h8877665544332211);
        push(8'h78);
        run_model("R11", 1'b0);

        // R5: identifier cut off by the record boundary
        clear_stream();
        push(8'h8D); push(8'h06); push(8'h00);
        push(8'h3C); push(8'h08); push(8'h00); push(8'h01); push(8'h02); push(8'h03);
        push(8'h78);
        run_model("R5", 1'b0);

        // R7: only the first complete identifier is kept
        clear_stream();
        push(8'h8D); push(8'h16); push(8'h00);
        push_id(8'h3C, 64'h1111111111111111);
        push_id(8'h3C, 64'h2222222222222222);
        push(8'h78);
        run_model("R7", 1'b0);

        // R9: stream ends with no terminator
        clear_stream();
        push(8'h8D); push(8'h0B); push(8'h00);
        push_id(8'h3C, 64'h0F0E0D0C0B0A0908);
        run_model("R9", 1'b0);

        // R4: random record mixes against the reading of the requirements
        for (int t = 0; t < 150; t++) begin
            gen_random();
            run_model("R4", 1'b1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule